// File: doc/BRIEF.md
# Clock-Configuration SMBus Register Slave

This block is the control-register side of a spread-spectrum clock generator. It sits on a two-wire SMBus-compatible bus as a slave at 7-bit address 0x6A. It keeps the generator's control bytes and drives them out as parallel configuration outputs. SCL and SDA are sampled with the faster system clock. The slave answers on SDA only by pulling the line low through an output-enable, so the pad stays open-drain.

The command byte picks how the registers are reached. When its top bit is set, the transfer touches one register, and the offset is held in the low seven bits. When the top bit is clear, the transfer is a block transfer. A block always starts at offset 0, and a byte-count byte comes before the data. On a read, the slave sends that count itself. Some configuration bits take their power-up values from strap inputs, which are loaded while reset is asserted.

Top module: `clk_cfg_smb_slave`

## Requirements
- R1: The slave acknowledges the address bytes 0xD4 (write) and 0xD5 (read). It does not acknowledge any other address byte and leaves the SDA line released for it.
- R2: A byte write sends 0xD4, then a command with bit 7 = 1 and the offset in bits 6:0, then one data byte. All three bytes are acknowledged, and the data updates the addressed register.
- R3: A byte read sends 0xD4, the command, a repeated START, 0xD5, and then one data byte. The slave returns the register at that offset, most significant bit first. A master NACK ends the transfer and SDA is released.
- R4: A block write sends command 0x00, then a byte-count byte whose value is ignored, then data bytes. The data bytes go to offsets 0, 1, 2, … in ascending order, and every byte is acknowledged. When a STOP follows any complete byte, the bytes received before it remain written.
- R5: A block read sends command 0x00, a repeated START, and 0xD5. The slave first returns the count 7, then the registers from offset 0 upward, until the master NACKs.
- R6: Reset values are as follows. Register 0 = {0, strap_ss_i[2:0], strap_freq_i, 0, 1, 0} (bit 7 down to bit 0; bit 1 is spread enable, bit 0 is the hardware/software select). Register 1 = 0x04 (bit 2 is the output enable, bits 1:0 are the pump setting). Register 6 = 0x08.
- R7: Some bits are reserved: register 0 bit 2, register 1 bits 7:3, and all of registers 2 to 5. They always read 0, and writes to them have no effect.
- R8: Register 6 is a read-only identifier. Writes to it are acknowledged and leave it at 0x08.
- R9: Offsets 7 to 127 are acknowledged, read as 0x00, and ignore writes.
- R10: The slave only pulls SDA low. It changes its SDA drive only while SCL is low, and it drives only during an acknowledge bit or a transmitted data bit.
- R11: cfg0_o and cfg1_o always show the current contents of registers 0 and 1.
- R12: Each data byte the slave accepts causes exactly one one-cycle register update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_ss_i | input | 3 | Strap value for register 0 bits 6:4 |
| strap_freq_i | input | 1 | Strap value for register 0 bit 3 |
| cfg0_o | output | 8 | Register 0 contents |
| cfg1_o | output | 8 | Register 1 contents |

## Verification
The assertions check three things on every cycle. The SDA drive stays fixed while SCL is high and is active only in acknowledge or transmit states. Register updates are single-cycle pulses. Reserved bits stay zero, and writes to any offset other than 0 and 1 leave the live outputs untouched. Only the bench scenarios can show the protocol results as a whole. These include address matching, byte and block data placement, the count byte on block reads, early termination by STOP or NACK, strap-loaded reset values, and the read-back values of every offset from 0 to 9.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
  parameter int unsigned NUM_REGS = 7;
  parameter int unsigned AW       = 7;
  localparam logic [6:0] DEV_ADDR  = 7'h6A;
  localparam logic [7:0] ID_VAL    = 8'h08;
  localparam logic [7:0] BLK_COUNT = 8'(NUM_REGS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_END, ST_RX_ACK, ST_TX, ST_TX_ACK
  } smb_state_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_CMD, PH_COUNT, PH_DATA
  } smb_phase_e;

  // writable bit mask per offset
  function automatic logic [7:0] wmask(int unsigned idx);
    case (idx)
      0:       return 8'hFB;
      1:       return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  // fixed part of the reset value (straps are ORed in by the bank)
  function automatic logic [7:0] rst_fixed(int unsigned idx);
    case (idx)
      0:       return 8'h02;
      1:       return 8'h04;
      6:       return ID_VAL;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s_o    = scl_pipe[STAGES-1];
  assign sda_s_o    = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_s_o & ~scl_d;
  assign scl_fall_o = ~scl_s_o & scl_d;
  // SDA edges while SCL stays high
  assign start_o    = scl_s_o & scl_d & sda_d & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_d & ~sda_d & sda_s_o;
endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm
  import clk_cfg_pkg::*;
#(
  parameter int unsigned PW = AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_s_i,
  input  logic          sda_s_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  output logic          sda_oe_o,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic [PW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i
);
  smb_state_e    state_q;
  smb_phase_e    phase_q;
  logic [7:0]    shift_q, tx_q;
  logic [2:0]    cnt_q;
  logic [PW-1:0] ptr_q;
  logic          rd_q, byte_mode_q, send_cnt_q, ack_pend_q, sda_oe_q;
  logic          wr_en_q;
  logic [PW-1:0] wr_addr_q;
  logic [7:0]    wr_data_q;
  logic [7:0]    rx_byte, tx_next;
  logic [PW-1:0] ptr_inc;

  assign rx_byte = {shift_q[6:0], sda_s_i};
  assign tx_next = send_cnt_q ? BLK_COUNT : rd_data_i;
  assign ptr_inc = ptr_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      phase_q     <= PH_ADDR;
      shift_q     <= '0;
      tx_q        <= '0;
      cnt_q       <= '0;
      ptr_q       <= '0;
      rd_q        <= 1'b0;
      byte_mode_q <= 1'b0;
      send_cnt_q  <= 1'b0;
      ack_pend_q  <= 1'b0;
      sda_oe_q    <= 1'b0;
      wr_en_q     <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        state_q  <= ST_RX;
        phase_q  <= PH_ADDR;
        cnt_q    <= '0;
        sda_oe_q <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        case (state_q)
          ST_RX: if (scl_rise_i) begin
            shift_q <= rx_byte;
            cnt_q   <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              state_q    <= ST_RX_END;
              ack_pend_q <= 1'b1;
              case (phase_q)
                PH_ADDR: begin
                  if (rx_byte[7:1] == DEV_ADDR) begin
                    rd_q       <= rx_byte[0];
                    send_cnt_q <= rx_byte[0] & ~byte_mode_q;
                    phase_q    <= PH_CMD;
                  end else begin
                    ack_pend_q <= 1'b0;
                  end
                end
                PH_CMD: begin
                  byte_mode_q <= rx_byte[7];
                  ptr_q       <= rx_byte[7] ? PW'(rx_byte[6:0]) : '0;
                  phase_q     <= rx_byte[7] ? PH_DATA : PH_COUNT;
                end
                PH_COUNT: phase_q <= PH_DATA;
                default: begin
                  wr_en_q   <= 1'b1;
                  wr_addr_q <= ptr_q;
                  wr_data_q <= rx_byte;
                  ptr_q     <= ptr_inc;
                end
              endcase
            end
          end
          ST_RX_END: if (scl_fall_i) begin
            if (ack_pend_q) begin
              sda_oe_q <= 1'b1;
              state_q  <= ST_RX_ACK;
            end else begin
              state_q  <= ST_IDLE;
            end
          end
          ST_RX_ACK: if (scl_fall_i) begin
            cnt_q <= '0;
            if (rd_q) begin
              tx_q     <= tx_next;
              sda_oe_q <= ~tx_next[7];
              state_q  <= ST_TX;
              if (send_cnt_q) send_cnt_q <= 1'b0;
              else            ptr_q      <= ptr_inc;
            end else begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_RX;
            end
          end
          ST_TX: if (scl_fall_i) begin
            if (cnt_q == 3'd7) begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_TX_ACK;
            end else begin
              cnt_q    <= cnt_q + 3'd1;
              tx_q     <= {tx_q[6:0], 1'b0};
              sda_oe_q <= ~tx_q[6];
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i && sda_s_i) begin
              state_q <= ST_IDLE;
            end else if (scl_fall_i) begin
              cnt_q    <= '0;
              tx_q     <= tx_next;
              sda_oe_q <= ~tx_next[7];
              state_q  <= ST_TX;
              if (send_cnt_q) send_cnt_q <= 1'b0;
              else            ptr_q      <= ptr_inc;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = sda_oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign rd_addr_o = ptr_q;

  AST_OE_HOLD_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s_i && !start_i && !stop_i) |=> $stable(sda_oe_q)) else $error("oe moved with SCL high"); // R10
  AST_OE_ONLY_ACK_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_q |-> (state_q == ST_RX_ACK || state_q == ST_TX)) else $error("oe outside ack/tx"); // R10
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |=> !wr_en_q) else $error("write pulse longer than one cycle"); // R12
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import clk_cfg_pkg::*;
#(
  parameter int unsigned NR = NUM_REGS,
  parameter int unsigned PW = AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    strap_ss_i,
  input  logic          strap_freq_i,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [PW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic [7:0]    cfg0_o,
  output logic [7:0]    cfg1_o
);
  localparam int unsigned IW = $clog2(NR);

  logic [7:0] regs [NR];
  logic [7:0] strap_bits;

  assign strap_bits = {1'b0, strap_ss_i, strap_freq_i, 3'b000};

  for (genvar g = 0; g < NR; g++) begin : g_reg
    localparam logic [7:0] WM = wmask(g);
    localparam logic [7:0] RV = rst_fixed(g);
    if (WM == 8'h00) begin : g_ro
      assign regs[g] = RV;
    end else begin : g_rw
      logic [7:0] q;
      logic [7:0] rv;
      assign rv = RV | ((g == 0) ? strap_bits : 8'h00);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                wr_q_reset: q <= rv;
        else if (wr_en_i && wr_addr_i == PW'(g))    q <= (q & ~WM) | (wr_data_i & WM);
      end
      assign regs[g] = q;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (int'(rd_addr_i) < NR) rd_data_o = regs[rd_addr_i[IW-1:0]];
  end

  assign cfg0_o = regs[0];
  assign cfg1_o = regs[1];

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg0_o[2] == 1'b0 && cfg1_o[7:3] == 5'd0)) else $error("reserved bit set"); // R7
  AST_FOREIGN_WR_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i > PW'(1)) |=> ($stable(cfg0_o) && $stable(cfg1_o))) else $error("write leaked"); // R8
endmodule

// File: rtl/clk_cfg_smb_slave.sv
module clk_cfg_smb_slave
  import clk_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_ss_i,
  input  logic       strap_freq_i,
  output logic [7:0] cfg0_o,
  output logic [7:0] cfg1_o
);
  logic          scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;

  smb_line_sync #(.STAGES(2)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s_o    (scl_s),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  smb_slave_fsm #(.PW(AW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data)
  );

  cfg_reg_bank #(.NR(NUM_REGS), .PW(AW)) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .strap_ss_i   (strap_ss_i),
    .strap_freq_i (strap_freq_i),
    .wr_en_i      (wr_en),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .rd_addr_i    (rd_addr),
    .rd_data_o    (rd_data),
    .cfg0_o       (cfg0_o),
    .cfg1_o       (cfg1_o)
  );
endmodule

// File: tb/clk_cfg_smb_slave_tb_top.sv
`timescale 1ns/1ps
module clk_cfg_smb_slave_tb_top;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap_ss = 3'b101;
  logic       strap_freq = 1'b1;
  logic       sda_oe;
  logic [7:0] cfg0, cfg1;
  logic       sda_line;
  int         checks = 0, errors = 0, oe_viol = 0;
  logic [7:0] exp_mem [10];
  logic       oe_prev = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  clk_cfg_smb_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_ss_i(strap_ss), .strap_freq_i(strap_freq),
    .cfg0_o(cfg0), .cfg1_o(cfg1)
  );

  // R10 monitor: slave drive must not move while master holds SCL high
  always @(negedge clk) begin
    if (rst_n && scl_m && (sda_oe !== oe_prev)) oe_viol++;
    oe_prev = sda_oe;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, expv);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_cyc(Q);
    scl_m = 1'b1; wait_cyc(Q);
    sda_m = 1'b0; wait_cyc(Q);
    scl_m = 1'b0; wait_cyc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_cyc(Q);
    scl_m = 1'b1; wait_cyc(Q);
    sda_m = 1'b1; wait_cyc(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_cyc(Q);
      scl_m = 1'b1; wait_cyc(2*Q);
      scl_m = 1'b0; wait_cyc(Q);
    end
    sda_m = 1'b1; wait_cyc(Q);
    scl_m = 1'b1; wait_cyc(Q);
    ack = ~sda_line; wait_cyc(Q);
    scl_m = 1'b0; wait_cyc(Q);
  endtask

  task automatic rd_byte(input logic ack_m, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_cyc(Q);
      scl_m = 1'b1; wait_cyc(Q);
      b[i] = sda_line; wait_cyc(Q);
      scl_m = 1'b0; wait_cyc(Q);
    end
    sda_m = ~ack_m; wait_cyc(Q);
    scl_m = 1'b1; wait_cyc(2*Q);
    scl_m = 1'b0; wait_cyc(Q);
    sda_m = 1'b1;
  endtask

  function automatic void model_wr(input int off, input logic [7:0] v);
    if (off == 0) exp_mem[0] = (exp_mem[0] & ~8'hFB) | (v & 8'hFB);
    else if (off == 1) exp_mem[1] = (exp_mem[1] & ~8'h07) | (v & 8'h07);
  endfunction

  function automatic string tag_of(input int off);
    if (off == 6) return "R8";
    if (off > 6) return "R9";
    if (off >= 2) return "R7";
    return "R3";
  endfunction

  task automatic byte_write(input int off, input logic [7:0] v, output logic ok);
    logic a0, a1, a2;
    bus_start();
    wr_byte(8'hD4, a0);
    wr_byte(8'h80 | 8'(off), a1);
    wr_byte(v, a2);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic byte_read(input int off, output logic [7:0] v, output logic ok);
    logic a0, a1, a2;
    bus_start();
    wr_byte(8'hD4, a0);
    wr_byte(8'h80 | 8'(off), a1);
    bus_start();
    wr_byte(8'hD5, a2);
    rd_byte(1'b0, v);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic ok, a;
    logic [7:0] wvals [3];
    wvals[0] = 8'hFF; wvals[1] = 8'h00; wvals[2] = 8'hA5;
    for (int i = 0; i < 10; i++) exp_mem[i] = 8'h00;
    exp_mem[0] = {1'b0, strap_ss, strap_freq, 3'b010};
    exp_mem[1] = 8'h04;
    exp_mem[6] = 8'h08;

    wait_cyc(10);
    rst_n = 1'b1;
    wait_cyc(5);
    // R6 reset state
    chk("R6 cfg0 reset", cfg0, 8'h5A);
    chk("R6 cfg1 reset", cfg1, 8'h04);
    chk("R10 idle oe", {7'd0, sda_oe}, 8'h00);

    // read sweep of offsets 0..9
    for (int off = 0; off < 10; off++) begin
      byte_read(off, v, ok);
      chk("R1 read acks", {7'd0, ok}, 8'h01);
      chk(tag_of(off), v, exp_mem[off]);
      chk("R3 released after NACK", {7'd0, sda_oe}, 8'h00);
    end

    // R1 foreign addresses
    bus_start(); wr_byte(8'hA0, a); bus_stop();
    chk("R1 foreign addr nack", {7'd0, a}, 8'h00);
    bus_start(); wr_byte(8'hD6, a); bus_stop();
    chk("R1 near addr nack", {7'd0, a}, 8'h00);
    chk("R1 cfg0 untouched", cfg0, exp_mem[0]);

    // write sweep with read-back
    for (int off = 0; off < 9; off++) begin
      for (int k = 0; k < 3; k++) begin
        byte_write(off, wvals[k], ok);
        model_wr(off, wvals[k]);
        chk("R2 write acks", {7'd0, ok}, 8'h01);
        chk("R11 cfg0", cfg0, exp_mem[0]);
        chk("R11 cfg1", cfg1, exp_mem[1]);
        byte_read(off, v, ok);
        chk(off < 2 ? "R2 readback" : tag_of(off), v, exp_mem[off]);
      end
    end

    // R4 / R12 full block write
    bus_start();
    wr_byte(8'hD4, a); chk("R4 addr ack", {7'd0, a}, 8'h01);
    wr_byte(8'h00, a); chk("R4 cmd ack", {7'd0, a}, 8'h01);
    wr_byte(8'h07, a); chk("R4 count ack", {7'd0, a}, 8'h01);
    for (int i = 0; i < 7; i++) begin
      wr_byte(8'h11 * 8'(i + 1), a);
      model_wr(i, 8'h11 * 8'(i + 1));
      chk("R4 data ack", {7'd0, a}, 8'h01);
    end
    bus_stop();
    chk("R4 R12 cfg0 block", cfg0, exp_mem[0]);
    chk("R4 R12 cfg1 block", cfg1, exp_mem[1]);

    // R4 STOP after first data byte
    bus_start();
    wr_byte(8'hD4, a); wr_byte(8'h00, a); wr_byte(8'h07, a);
    wr_byte(8'h96, a); model_wr(0, 8'h96);
    bus_stop();
    chk("R4 partial cfg0", cfg0, exp_mem[0]);
    chk("R4 partial cfg1 kept", cfg1, exp_mem[1]);

    // R5 full block read
    bus_start();
    wr_byte(8'hD4, a); wr_byte(8'h00, a);
    bus_start();
    wr_byte(8'hD5, a); chk("R5 read addr ack", {7'd0, a}, 8'h01);
    rd_byte(1'b1, v); chk("R5 count", v, 8'h07);
    for (int i = 0; i < 7; i++) begin
      rd_byte(i < 6, v);
      chk("R5 block data", v, exp_mem[i]);
    end
    bus_stop();
    chk("R5 released", {7'd0, sda_oe}, 8'h00);

    // R5 early NACK after register 0, then fresh byte read
    bus_start();
    wr_byte(8'hD4, a); wr_byte(8'h00, a);
    bus_start();
    wr_byte(8'hD5, a);
    rd_byte(1'b1, v); chk("R5 count again", v, 8'h07);
    rd_byte(1'b0, v); chk("R5 early reg0", v, exp_mem[0]);
    bus_stop();
    byte_read(1, v, ok);
    chk("R5 after early end", v, exp_mem[1]);

    checks++;
    if (oe_viol != 0) begin
      errors++;
      $display("FAIL R10 actual=%0d expected=0 oe changes with SCL high", oe_viol);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule